// File: doc/BRIEF.md
# Rate-Corrected Seconds and Minutes Divider

This block turns a 512 Hz tick enable into a one-cycle seconds pulse and a one-cycle minutes pulse. A seconds count and a minute index kept modulo 16 are held internally. The rate can be trimmed digitally: a 5-bit magnitude N and a direction bit choose how many seconds of one chosen minute are shortened or lengthened by a single tick.

The trim is asymmetric. Speeding up shortens the first N seconds of every 8th minute to one tick less than nominal. Slowing down lengthens the first N seconds of every 16th minute by one tick. For the same N, the speed-up trim therefore carries twice the weight of the slow-down trim, which matches a crystal that mostly runs slow away from room temperature. The calibration inputs are sampled once per second, so they may be changed at any time.

Top module: `rtc_cal_sec`

## Requirements
- R1: `sec_pulse` is high for exactly one clock cycle, in the cycle after the `tick_en` cycle that completes a second, and is never high at any other time.
- R2: With no trim in effect, a second lasts exactly TICKS_PER_SEC cycles in which `tick_en` is high. Cycles with `tick_en` low do not advance the count.
- R3: With `cal_fast`=1 and magnitude N>0, seconds 0 to N-1 of every minute whose index is 0 modulo 8 last TICKS_PER_SEC-1 ticks. All other seconds are nominal.
- R4: With `cal_fast`=0 and magnitude N>0, seconds 0 to N-1 of every minute whose index is 0 modulo 16 last TICKS_PER_SEC+1 ticks. A minute whose index is 8 modulo 16 is nominal.
- R5: A magnitude of 0 gives nominal seconds in every minute, whatever the value of `cal_fast`.
- R6: `min_pulse` goes high together with `sec_pulse` exactly when the second count wraps from SEC_PER_MIN-1 to 0, which is once every SEC_PER_MIN seconds. It is low at all other times.
- R7: `cal_mag` and `cal_fast` are sampled on the edge that ends each second, and on every reset cycle. A change made in the middle of a second affects only the seconds that follow.
- R8: A synchronous active-high `rst` clears the tick count, the second count and the minute index, and holds both pulses low. The first second after reset is second 0 of minute 0 and uses the trim present on the last reset cycle.
- R9: With speed-up and magnitude N, the 8 minutes that follow reset total exactly 8·SEC_PER_MIN·TICKS_PER_SEC−N ticks. With slow-down and magnitude N, the 16 minutes that follow reset total exactly 16·SEC_PER_MIN·TICKS_PER_SEC+N ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | 512 Hz tick, one cycle wide |
| cal_mag | input | CAL_W (5) | Trim magnitude N, the number of seconds adjusted |
| cal_fast | input | 1 | Trim direction: 1 shortens seconds, 0 lengthens them |
| sec_pulse | output | 1 | One-cycle pulse at the end of each second |
| min_pulse | output | 1 | One-cycle pulse at the end of each minute (tied low when MIN_PULSE_EN=0) |

## Verification
The bench uses a reduced tick and seconds count so that whole 8- and 16-minute spans fit into the run. It measures each second in ticks against a model and sums whole spans. A design that applied the trim to the wrong minute, or that used the 8-minute cycle for slow-down, would fail the check on minute 8 or a span total. A design that applied N+1 or N-1 seconds would be off by one tick in the span total. A directed case changes the magnitude part-way through second 0. A design that did not sample the trim at the second boundary would shorten that second. Random tick gaps, random trim changes, and the edge values N=0 and N=31 are used to test gating by `tick_en` and the limits of the magnitude.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   // Length class of the second currently being counted
   typedef enum logic [1:0] {
      LEN_NOM   = 2'd0,
      LEN_SHORT = 2'd1,
      LEN_LONG  = 2'd2
   } len_kind_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rtc_cal_len.sv
module rtc_cal_len
   import rtc_cal_pkg::*;
#(
   parameter int unsigned CAL_W     = 5,
   parameter int unsigned SEC_W     = 6,
   parameter int unsigned MIN_W     = 4,
   parameter int unsigned FAST_LOG2 = 3,
   parameter int unsigned SLOW_LOG2 = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cal_fast_q,
   input  logic [CAL_W-1:0]  cal_mag_q,
   input  logic [SEC_W-1:0]  sec_cnt,
   input  logic [MIN_W-1:0]  min_cnt,
   output len_kind_e         kind
);

   localparam int unsigned CMP_W = max2(CAL_W, SEC_W);

   generate
      if (FAST_LOG2 < 1 || FAST_LOG2 > MIN_W) begin : g_bad_fast
         $error("rtc_cal_len: FAST_LOG2 must lie in 1..MIN_W");
      end
      if (SLOW_LOG2 < 1 || SLOW_LOG2 > MIN_W) begin : g_bad_slow
         $error("rtc_cal_len: SLOW_LOG2 must lie in 1..MIN_W");
      end
   endgenerate

   logic [CMP_W-1:0] sec_ext;
   logic [CMP_W-1:0] mag_ext;
   logic             in_window;
   logic             fast_min;
   logic             slow_min;

   assign sec_ext   = CMP_W'(sec_cnt);
   assign mag_ext   = CMP_W'(cal_mag_q);
   assign in_window = (sec_ext < mag_ext);
   assign fast_min  = (min_cnt[FAST_LOG2-1:0] == '0);
   assign slow_min  = (min_cnt[SLOW_LOG2-1:0] == '0);

   always_comb begin
      kind = LEN_NOM;
      if (in_window) begin
         if (cal_fast_q && fast_min)       kind = LEN_SHORT;
         else if (!cal_fast_q && slow_min) kind = LEN_LONG;
      end
   end

   // R4: a long second only ever falls in a slow-down correcting minute
   a_r4_long_in_slow_min: assert property (@(posedge clk) disable iff (rst)
      (kind == LEN_LONG) |-> (!cal_fast_q && min_cnt[SLOW_LOG2-1:0] == '0));

   // R5: a zero magnitude never yields an adjusted second
   a_r5_zero_mag_nominal: assert property (@(posedge clk) disable iff (rst)
      (cal_mag_q == '0) |-> (kind == LEN_NOM));

endmodule

// File: rtl/rtc_cal_tickdiv.sv
module rtc_cal_tickdiv
   import rtc_cal_pkg::*;
#(
   parameter int unsigned TICKS_PER_SEC = 512
) (
   input  logic      clk,
   input  logic      rst,
   input  logic      tick_en,
   input  len_kind_e kind,
   output logic      sec_end
);

   localparam int unsigned TC_W = $clog2(TICKS_PER_SEC + 1);

   generate
      if (TICKS_PER_SEC < 4) begin : g_bad_ticks
         $error("rtc_cal_tickdiv: TICKS_PER_SEC must be at least 4");
      end
   endgenerate

   logic [TC_W-1:0] tc_q;
   logic [TC_W-1:0] term;

   always_comb begin
      unique case (kind)
         LEN_SHORT: term = TC_W'(TICKS_PER_SEC - 2);
         LEN_LONG:  term = TC_W'(TICKS_PER_SEC);
         default:   term = TC_W'(TICKS_PER_SEC - 1);
      endcase
   end

   assign sec_end = tick_en && (tc_q == term);

   always_ff @(posedge clk) begin
      if (rst) begin
         tc_q <= '0;
      end else if (tick_en) begin
         tc_q <= (tc_q == term) ? '0 : tc_q + 1'b1;
      end
   end

   // R2: the tick count never runs past the longest second
   a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
      tc_q <= TC_W'(TICKS_PER_SEC));

   // R2: cycles without a tick leave the count untouched
   a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
      !tick_en |=> $stable(tc_q));

endmodule

// File: rtl/rtc_cal_timectr.sv
module rtc_cal_timectr #(
   parameter int unsigned SEC_PER_MIN = 60,
   parameter int unsigned MIN_W       = 4
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           sec_end,
   output logic [$clog2(SEC_PER_MIN)-1:0] sec_cnt,
   output logic [MIN_W-1:0]               min_cnt,
   output logic                           wrap
);

   localparam int unsigned SEC_W    = $clog2(SEC_PER_MIN);
   localparam int unsigned SEC_LAST = SEC_PER_MIN - 1;

   generate
      if (SEC_PER_MIN < 2) begin : g_bad_spm
         $error("rtc_cal_timectr: SEC_PER_MIN must be at least 2");
      end
   endgenerate

   assign wrap = sec_end && (sec_cnt == SEC_W'(SEC_LAST));

   always_ff @(posedge clk) begin
      if (rst) begin
         sec_cnt <= '0;
         min_cnt <= '0;
      end else if (sec_end) begin
         if (wrap) begin
            sec_cnt <= '0;
            min_cnt <= min_cnt + 1'b1;
         end else begin
            sec_cnt <= sec_cnt + 1'b1;
         end
      end
   end

   // R6: the second count stays below the minute length
   a_r6_sec_range: assert property (@(posedge clk) disable iff (rst)
      sec_cnt <= SEC_W'(SEC_LAST));

   // R6: a wrap restarts the minute at second 0
   a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
      wrap |=> (sec_cnt == '0));

endmodule

// File: rtl/rtc_cal_sec.sv
module rtc_cal_sec
   import rtc_cal_pkg::*;
#(
   parameter int unsigned TICKS_PER_SEC = 512,
   parameter int unsigned SEC_PER_MIN   = 60,
   parameter int unsigned CAL_W         = 5,
   parameter int unsigned FAST_LOG2     = 3,
   parameter int unsigned SLOW_LOG2     = 4,
   parameter bit          MIN_PULSE_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick_en,
   input  logic [CAL_W-1:0] cal_mag,
   input  logic             cal_fast,
   output logic             sec_pulse,
   output logic             min_pulse
);

   localparam int unsigned SEC_W = $clog2(SEC_PER_MIN);
   localparam int unsigned MIN_W = max2(FAST_LOG2, SLOW_LOG2);

   generate
      if ((1 << CAL_W) - 1 >= SEC_PER_MIN) begin : g_bad_cal
         $error("rtc_cal_sec: the largest magnitude must be below SEC_PER_MIN");
      end
   endgenerate

   logic             cal_fast_q;
   logic [CAL_W-1:0] cal_mag_q;
   logic [SEC_W-1:0] sec_cnt;
   logic [MIN_W-1:0] min_cnt;
   logic             sec_end;
   logic             wrap;
   len_kind_e        kind;

   // Trim is sampled per second so a mid-second write waits for the boundary
   always_ff @(posedge clk) begin
      if (rst || sec_end) begin
         cal_fast_q <= cal_fast;
         cal_mag_q  <= cal_mag;
      end
   end

   rtc_cal_len #(
      .CAL_W     (CAL_W),
      .SEC_W     (SEC_W),
      .MIN_W     (MIN_W),
      .FAST_LOG2 (FAST_LOG2),
      .SLOW_LOG2 (SLOW_LOG2)
   ) u_len (
      .clk        (clk),
      .rst        (rst),
      .cal_fast_q (cal_fast_q),
      .cal_mag_q  (cal_mag_q),
      .sec_cnt    (sec_cnt),
      .min_cnt    (min_cnt),
      .kind       (kind)
   );

   rtc_cal_tickdiv #(
      .TICKS_PER_SEC (TICKS_PER_SEC)
   ) u_tickdiv (
      .clk     (clk),
      .rst     (rst),
      .tick_en (tick_en),
      .kind    (kind),
      .sec_end (sec_end)
   );

   rtc_cal_timectr #(
      .SEC_PER_MIN (SEC_PER_MIN),
      .MIN_W       (MIN_W)
   ) u_time (
      .clk     (clk),
      .rst     (rst),
      .sec_end (sec_end),
      .sec_cnt (sec_cnt),
      .min_cnt (min_cnt),
      .wrap    (wrap)
   );

   always_ff @(posedge clk) begin
      if (rst) sec_pulse <= 1'b0;
      else     sec_pulse <= sec_end;
   end

   generate
      if (MIN_PULSE_EN) begin : g_min
         logic min_q;
         always_ff @(posedge clk) begin
            if (rst) min_q <= 1'b0;
            else     min_q <= wrap;
         end
         assign min_pulse = min_q;

         // R6: a minute pulse always coincides with a seconds pulse
         a_r6_min_with_sec: assert property (@(posedge clk) disable iff (rst)
            min_pulse |-> sec_pulse);
      end else begin : g_no_min
         assign min_pulse = 1'b0;
      end
   endgenerate

   // R1: the seconds pulse lasts exactly one cycle
   a_r1_sec_one_cycle: assert property (@(posedge clk) disable iff (rst)
      sec_pulse |=> !sec_pulse);

   // R1: the seconds pulse follows a tick cycle
   a_r1_sec_after_tick: assert property (@(posedge clk) disable iff (rst)
      $rose(sec_pulse) |-> $past(tick_en));

   // R7: the sampled trim holds still inside a second
   a_r7_cal_hold: assert property (@(posedge clk) disable iff (rst)
      !sec_end |=> ($stable(cal_mag_q) && $stable(cal_fast_q)));

endmodule

// File: tb/rtc_cal_sec_bench.sv
`timescale 1ns/1ps
module rtc_cal_sec_bench;

   localparam int T  = 16;
   localparam int S  = 40;
   localparam int CW = 5;

   logic          clk = 1'b0;
   logic          rst;
   logic          tick_en;
   logic [CW-1:0] cal_mag;
   logic          cal_fast;
   logic          sec_pulse;
   logic          min_pulse;

   always #2 clk = ~clk;

   rtc_cal_sec #(
      .TICKS_PER_SEC (T),
      .SEC_PER_MIN   (S),
      .CAL_W         (CW),
      .FAST_LOG2     (3),
      .SLOW_LOG2     (4),
      .MIN_PULSE_EN  (1'b1)
   ) u_rtc_cal_sec (
      .clk       (clk),
      .rst       (rst),
      .tick_en   (tick_en),
      .cal_mag   (cal_mag),
      .cal_fast  (cal_fast),
      .sec_pulse (sec_pulse),
      .min_pulse (min_pulse)
   );

   int    total = 0;
   int    bad   = 0;
   int    m_sec, m_min, m_ticks, m_mag, pulses;
   bit    m_fast, m_chg;
   longint span_acc;

   function automatic int exp_len(int s, int mi, bit f, int n);
      if (n == 0 || s >= n) return T;
      if (f && (mi % 8) == 0) return T - 1;
      if (!f && (mi % 16) == 0) return T + 1;
      return T;
   endfunction

   task automatic check(bit ok, string tag, longint act, longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic set_cal(bit f, int n);
      cal_fast = f;
      cal_mag  = CW'(n);
      m_chg    = 1'b1;
   endtask

   task automatic step(bit te);
      int  e;
      string tag;
      @(negedge clk);
      tick_en = te;
      @(posedge clk);
      #1;
      if (te) m_ticks++;
      e = exp_len(m_sec, m_min, m_fast, m_mag);
      if (sec_pulse) begin
         if (m_chg)                tag = "R7";
         else if (m_mag == 0)      tag = "R5";
         else if (e == T - 1)      tag = "R3";
         else if (e == T + 1)      tag = "R4";
         else if (m_min % 8 == 0)  tag = "R4";
         else                      tag = "R2";
         check(m_ticks == e, tag, m_ticks, e);
         check(min_pulse == (m_sec == S - 1), "R6", min_pulse, (m_sec == S - 1));
         span_acc += m_ticks;
         m_ticks = 0;
         pulses++;
         if (m_sec == S - 1) begin
            m_sec = 0;
            m_min = (m_min + 1) % 16;
         end else begin
            m_sec++;
         end
         m_fast = cal_fast;
         m_mag  = int'(cal_mag);
         m_chg  = 1'b0;
      end else begin
         if (min_pulse) check(1'b0, "R6", 1, 0);
         if (m_ticks > e) begin
            check(1'b0, "R1", m_ticks, e);
            m_ticks = 0;
         end
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      tick_en = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(posedge clk);
         #1;
         check(!sec_pulse && !min_pulse, "R8", {sec_pulse, min_pulse}, 0);
      end
      @(negedge clk);
      rst = 1'b0;
      tick_en = 1'b0;
      m_sec = 0; m_min = 0; m_ticks = 0; pulses = 0; span_acc = 0;
      m_fast = cal_fast; m_mag = int'(cal_mag); m_chg = 1'b0;
   endtask

   task automatic run_pulses(int n, int pct, int chg_rate);
      while (pulses < n) begin
         if (chg_rate != 0 && $urandom_range(chg_rate - 1) == 0)
            set_cal(1'($urandom_range(1)), $urandom_range(31));
         step($urandom_range(99) < pct);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      rst = 1'b1; tick_en = 1'b0; cal_fast = 1'b1; cal_mag = CW'(2);

      // R9 / R3 / R8: speed-up span of 8 minutes
      do_reset();
      run_pulses(8 * S, 75, 0);
      check(span_acc == 8 * S * T - 2, "R9", span_acc, 8 * S * T - 2);

      // R9 / R4: slow-down span of 16 minutes, minute 8 stays nominal
      cal_fast = 1'b0; cal_mag = CW'(3);
      do_reset();
      run_pulses(16 * S, 80, 0);
      check(span_acc == 16 * S * T + 3, "R9", span_acc, 16 * S * T + 3);

      // R5: zero magnitude over a correcting minute
      cal_fast = 1'b1; cal_mag = '0;
      do_reset();
      run_pulses(S, 100, 0);
      check(span_acc == S * T, "R5", span_acc, S * T);

      // R7: magnitude raised to 31 part-way through second 0
      cal_fast = 1'b1; cal_mag = '0;
      do_reset();
      for (int i = 0; i < 5; i++) step(1'b1);
      set_cal(1'b1, 31);
      run_pulses(S, 100, 0);
      check(span_acc == S * T - 30, "R7", span_acc, S * T - 30);

      // R3 / R4 / R7: random trim and tick gaps
      cal_fast = 1'($urandom_range(1)); cal_mag = CW'($urandom_range(31));
      do_reset();
      run_pulses(20 * S, 70, 150);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule